// File: doc/BRIEF.md
# Light-Load Pulse and Rectifier Mode Manager

This block sits between the loop's duty demand and the gate sequencer of a phase-shifted full bridge. At every power-cycle boundary it decides how wide the next primary pulse is. The pulse is either the demanded width, the programmed minimum width, or nothing. The same boundary also drives a second decision: whether the synchronous rectifiers are driven (continuous conduction) or held off (discontinuous conduction). The cycle boundary arrives as a one-clock strobe. Legs alternate on every strobe. The A/D leg pair and the B/C leg pair take turns, and the leg of the commanded cycle is reported alongside the width.

When the demand falls below the minimum width, the block starts a burst on an A/D cycle. A burst is a fixed even number of minimum-width pulses, so it always finishes on a B/C cycle. After a burst, a demand that is still too small stops all pulses until the demand recovers. A width limit from the current-limit path caps every pulse, including burst pulses. The rectifier mode changes only after a set number of consecutive qualifying cycles, and a hysteresis offset is added to the threshold while the block is in discontinuous mode. Two straps pin the rectifier mode to one state or the other.

Top module: `lload_mgr`

## Requirements
- R1: After reset, pw_o is 0, burst_o is 0, sr_en_o is 1 and leg_o is 1, so the first strobe commands an A/D cycle.
- R2: Outputs change only on a clock edge where cyc_stb is 1. In normal operation pw_o becomes min(max(demand_i, effective TMIN), ilim_i) on that edge.
- R3: The effective TMIN is tmin_i, raised to TMIN_FLOOR (default 4) when tmin_i is below it.
- R4: In normal operation, a demand below the effective TMIN on a strobe whose next leg is A/D starts a burst (burst_o = 1). The burst has 2*BURST_PAIRS pulses (default 2) of minimum width. If the next leg is B/C, the block issues a minimum-width pulse without entering a burst. A burst ends on a B/C cycle.
- R5: At the first strobe after the last burst pulse, a demand still below the effective TMIN gives pw_o = 0 and burst_o = 0. Zero pulses continue until a strobe sees demand at or above the effective TMIN. On that strobe the block resumes normal widths, and the burst count is reset.
- R6: ilim_i caps every pulse width, with priority over both the demand and TMIN, including during a burst.
- R7: In continuous mode (sr_en_o = 1), the block switches to discontinuous mode (sr_en_o = 0) after QUAL_N (default 2) consecutive strobes with cs_i < dcm_thr_i. A non-qualifying strobe restarts the count.
- R8: In discontinuous mode, the block returns to continuous mode after QUAL_N consecutive strobes with cs_i >= dcm_thr_i + dcm_hyst_i.
- R9: force_dcm_i = 1 drives sr_en_o to 0 on the next clock edge and holds it there. no_dcm_i = 1 (with force_dcm_i = 0) drives sr_en_o to 1 in the same way. Neither strap waits for a strobe, and force has priority.
- R10: leg_o toggles on every strobe. The value 0 marks an A/D cycle and 1 marks a B/C cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_stb | input | 1 | One-clock strobe at each power-cycle boundary |
| demand_i | input | PW_W | Pulse width demanded by the loop |
| tmin_i | input | PW_W | Programmed minimum pulse width |
| ilim_i | input | PW_W | Width cap from the current-limit path |
| cs_i | input | CS_W | Sensed current word |
| dcm_thr_i | input | CS_W | Discontinuous-mode threshold |
| dcm_hyst_i | input | CS_W | Hysteresis offset applied while discontinuous |
| force_dcm_i | input | 1 | Strap: hold discontinuous mode |
| no_dcm_i | input | 1 | Strap: hold continuous mode |
| pw_o | output | PW_W | Pulse width command for the next cycle |
| leg_o | output | 1 | Leg of the commanded cycle, 0 = A/D, 1 = B/C |
| sr_en_o | output | 1 | Synchronous rectifier enable |
| burst_o | output | 1 | Burst in progress |

## Verification
Some properties hold on every cycle, and the assertions check those. The width changes only on strobes. The width never exceeds the cap sampled on that strobe. The halted state never carries a width. Bursts always exit onto an A/D cycle. The leg toggles on each strobe. The straps win immediately. A rectifier mode change without a strap always follows a strobe. The bench scenarios cover the parts that depend on sequences and values. These include the exact widths chosen from demand, TMIN floor and cap, the number of pulses in a burst, and the halt and resume decision. They also include the two-cycle qualification and the hysteresis band, where a single qualifying cycle or a level inside the band must leave the mode unchanged.

// File: rtl/llm_pkg.sv
package llm_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_BURST, ST_HALT} pstate_e;
  localparam logic LEG_AD = 1'b0;
  localparam logic LEG_BC = 1'b1;
endpackage

// File: rtl/pw_clamp.sv
module pw_clamp #(
  parameter int PW_W       = 8,
  parameter int TMIN_FLOOR = 4
) (
  input  logic [PW_W-1:0] demand_i,
  input  logic [PW_W-1:0] tmin_i,
  input  logic [PW_W-1:0] ilim_i,
  output logic            short_o,
  output logic [PW_W-1:0] run_w_o,
  output logic [PW_W-1:0] burst_w_o
);
  localparam logic [PW_W-1:0] FLOOR_W = PW_W'(TMIN_FLOOR);

  logic [PW_W-1:0] tmin_eff;
  logic [PW_W-1:0] floor_w;

  always_comb begin
    tmin_eff  = (tmin_i < FLOOR_W) ? FLOOR_W : tmin_i;
    short_o   = (demand_i < tmin_eff);
    floor_w   = short_o ? tmin_eff : demand_i;
    run_w_o   = (floor_w < ilim_i) ? floor_w : ilim_i;
    burst_w_o = (tmin_eff < ilim_i) ? tmin_eff : ilim_i;
  end
endmodule

// File: rtl/burst_fsm.sv
module burst_fsm
  import llm_pkg::*;
#(
  parameter int PW_W        = 8,
  parameter int BURST_PAIRS = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stb_i,
  input  logic            short_i,
  input  logic [PW_W-1:0] run_w_i,
  input  logic [PW_W-1:0] burst_w_i,
  output logic [PW_W-1:0] pw_o,
  output logic            leg_o,
  output logic            burst_o
);
  localparam int BURST_LEN = 2 * BURST_PAIRS;
  localparam int CNT_W     = $clog2(BURST_LEN + 1);
  localparam logic [CNT_W-1:0] LEN_C = CNT_W'(BURST_LEN);

  pstate_e         state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PW_W-1:0]  pw_q, pw_d;
  logic             leg_q, leg_d;
  logic             nleg;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    pw_d    = pw_q;
    leg_d   = leg_q;
    nleg    = ~leg_q;
    if (stb_i) begin
      leg_d = nleg;
      case (state_q)
        ST_RUN: begin
          if (short_i && (nleg == LEG_AD)) begin
            state_d = ST_BURST;
            cnt_d   = CNT_W'(1);
            pw_d    = burst_w_i;
          end else begin
            pw_d = run_w_i;
          end
        end
        ST_BURST: begin
          if (cnt_q < LEN_C) begin
            cnt_d = cnt_q + 1'b1;
            pw_d  = burst_w_i;
          end else if (short_i) begin
            state_d = ST_HALT;
            cnt_d   = '0;
            pw_d    = '0;
          end else begin
            state_d = ST_RUN;
            cnt_d   = '0;
            pw_d    = run_w_i;
          end
        end
        ST_HALT: begin
          if (!short_i) begin
            state_d = ST_RUN;
            cnt_d   = '0;
            pw_d    = run_w_i;
          end else begin
            pw_d = '0;
          end
        end
        default: begin
          state_d = ST_RUN;
          cnt_d   = '0;
          pw_d    = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
      pw_q    <= '0;
      leg_q   <= LEG_BC;
    end else if (stb_i) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pw_q    <= pw_d;
      leg_q   <= leg_d;
    end
  end

  assign pw_o    = pw_q;
  assign leg_o   = leg_q;
  assign burst_o = (state_q == ST_BURST);

  // R2
  pw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(stb_i) |-> $stable(pw_q));
  // R5
  halt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HALT) |-> (pw_q == '0));
  // R4
  burst_exit_leg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(burst_o) |-> (leg_q == LEG_AD));
  // R10
  leg_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stb_i) |-> (leg_q != $past(leg_q)));
endmodule

// File: rtl/dcm_tracker.sv
module dcm_tracker #(
  parameter int CS_W   = 8,
  parameter int QUAL_N = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stb_i,
  input  logic [CS_W-1:0] cs_i,
  input  logic [CS_W-1:0] thr_i,
  input  logic [CS_W-1:0] hyst_i,
  input  logic            force_i,
  input  logic            nodcm_i,
  output logic            sr_en_o
);
  localparam int Q_W = $clog2(QUAL_N + 1);
  localparam logic [Q_W-1:0] LAST_Q = Q_W'(QUAL_N - 1);

  logic           mode_q, mode_d;
  logic [Q_W-1:0] q_q, q_d;
  logic [CS_W:0]  thr_eff;
  logic           cond;

  always_comb begin
    thr_eff = mode_q ? ({1'b0, thr_i} + {1'b0, hyst_i}) : {1'b0, thr_i};
    cond    = mode_q ? ({1'b0, cs_i} >= thr_eff) : ({1'b0, cs_i} < thr_eff);
    mode_d  = mode_q;
    q_d     = q_q;
    if (force_i) begin
      mode_d = 1'b1;
      q_d    = '0;
    end else if (nodcm_i) begin
      mode_d = 1'b0;
      q_d    = '0;
    end else if (stb_i) begin
      if (cond) begin
        if (q_q == LAST_Q) begin
          mode_d = ~mode_q;
          q_d    = '0;
        end else begin
          q_d = q_q + 1'b1;
        end
      end else begin
        q_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      q_q    <= '0;
    end else if (stb_i || force_i || nodcm_i) begin
      mode_q <= mode_d;
      q_q    <= q_d;
    end
  end

  assign sr_en_o = ~mode_q;

  // R9
  force_dcm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(force_i) |-> !sr_en_o);
  // R9
  no_dcm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(nodcm_i) && !$past(force_i)) |-> sr_en_o);
  // R7
  mode_on_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q != $past(mode_q)) && !$past(force_i) && !$past(nodcm_i)) |-> $past(stb_i));
endmodule

// File: rtl/lload_mgr.sv
module lload_mgr #(
  parameter int PW_W        = 8,
  parameter int CS_W        = 8,
  parameter int TMIN_FLOOR  = 4,
  parameter int BURST_PAIRS = 1,
  parameter int QUAL_N      = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cyc_stb,
  input  logic [PW_W-1:0] demand_i,
  input  logic [PW_W-1:0] tmin_i,
  input  logic [PW_W-1:0] ilim_i,
  input  logic [CS_W-1:0] cs_i,
  input  logic [CS_W-1:0] dcm_thr_i,
  input  logic [CS_W-1:0] dcm_hyst_i,
  input  logic            force_dcm_i,
  input  logic            no_dcm_i,
  output logic [PW_W-1:0] pw_o,
  output logic            leg_o,
  output logic            sr_en_o,
  output logic            burst_o
);
  logic            short_w;
  logic [PW_W-1:0] run_w;
  logic [PW_W-1:0] burst_w;

  pw_clamp #(.PW_W(PW_W), .TMIN_FLOOR(TMIN_FLOOR)) u_clamp (
    .demand_i (demand_i),
    .tmin_i   (tmin_i),
    .ilim_i   (ilim_i),
    .short_o  (short_w),
    .run_w_o  (run_w),
    .burst_w_o(burst_w)
  );

  burst_fsm #(.PW_W(PW_W), .BURST_PAIRS(BURST_PAIRS)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb_i    (cyc_stb),
    .short_i  (short_w),
    .run_w_i  (run_w),
    .burst_w_i(burst_w),
    .pw_o     (pw_o),
    .leg_o    (leg_o),
    .burst_o  (burst_o)
  );

  dcm_tracker #(.CS_W(CS_W), .QUAL_N(QUAL_N)) u_dcm (
    .clk    (clk),
    .rst_n  (rst_n),
    .stb_i  (cyc_stb),
    .cs_i   (cs_i),
    .thr_i  (dcm_thr_i),
    .hyst_i (dcm_hyst_i),
    .force_i(force_dcm_i),
    .nodcm_i(no_dcm_i),
    .sr_en_o(sr_en_o)
  );

  // R6
  ilim_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cyc_stb) |-> (pw_o <= $past(ilim_i)));
endmodule

// File: tb/lload_mgr_tb.sv
module lload_mgr_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_stb = 1'b0;
  logic [7:0] demand_i = '0, tmin_i = '0, ilim_i = '0;
  logic [7:0] cs_i = 8'd200, dcm_thr_i = 8'd50, dcm_hyst_i = 8'd10;
  logic       force_dcm_i = 1'b0, no_dcm_i = 1'b0;
  logic [7:0] pw_o;
  logic       leg_o, sr_en_o, burst_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lload_mgr u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb),
    .demand_i(demand_i), .tmin_i(tmin_i), .ilim_i(ilim_i),
    .cs_i(cs_i), .dcm_thr_i(dcm_thr_i), .dcm_hyst_i(dcm_hyst_i),
    .force_dcm_i(force_dcm_i), .no_dcm_i(no_dcm_i),
    .pw_o(pw_o), .leg_o(leg_o), .sr_en_o(sr_en_o), .burst_o(burst_o)
  );

  typedef struct packed {
    logic [7:0] d;
    logic [7:0] t;
    logic [7:0] i;
    logic [7:0] e;
  } vec_t;

  // demand, tmin, ilim, expected width; even rows are A/D cycles
  localparam vec_t VEC [8] = '{
    '{8'd50,  8'd10,  8'd200, 8'd50},
    '{8'd50,  8'd10,  8'd30,  8'd30},
    '{8'd120, 8'd100, 8'd255, 8'd120},
    '{8'd1,   8'd0,   8'd200, 8'd4},
    '{8'd40,  8'd30,  8'd255, 8'd40},
    '{8'd5,   8'd30,  8'd255, 8'd30},
    '{8'd255, 8'd10,  8'd100, 8'd100},
    '{8'd0,   8'd3,   8'd2,   8'd2}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic strobe();
    cyc_stb = 1'b1;
    @(negedge clk);
    cyc_stb = 1'b0;
  endtask

  task automatic set_pw(input int d, input int t, input int i);
    demand_i = 8'(d);
    tmin_i   = 8'(t);
    ilim_i   = 8'(i);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 pw", int'(pw_o), 0);
    chk("R1 burst", int'(burst_o), 0);
    chk("R1 sr_en", int'(sr_en_o), 1);
    chk("R1 leg", int'(leg_o), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R6 R10 table walk
    for (int k = 0; k < 8; k++) begin
      set_pw(int'(VEC[k].d), int'(VEC[k].t), int'(VEC[k].i));
      strobe();
      chk("R2 width", int'(pw_o), int'(VEC[k].e));
      chk("R10 leg", int'(leg_o), k % 2);
      chk("R4 no burst", int'(burst_o), 0);
    end

    // R2 hold between strobes
    set_pw(99, 10, 255);
    repeat (3) @(negedge clk);
    chk("R2 hold", int'(pw_o), 2);

    // R4 burst from A/D leg
    set_pw(5, 20, 255);
    strobe();
    chk("R4 pulse1", int'(pw_o), 20);
    chk("R4 burst1", int'(burst_o), 1);
    chk("R4 leg1", int'(leg_o), 0);
    strobe();
    chk("R4 pulse2", int'(pw_o), 20);
    chk("R4 leg2 ends on B/C", int'(leg_o), 1);
    // R5 halt
    strobe();
    chk("R5 halt pw", int'(pw_o), 0);
    chk("R5 halt burst", int'(burst_o), 0);
    strobe();
    chk("R5 halt hold", int'(pw_o), 0);
    set_pw(25, 20, 255);
    strobe();
    chk("R5 resume", int'(pw_o), 25);
    chk("R5 resume leg", int'(leg_o), 0);
    set_pw(30, 20, 255);
    strobe();
    chk("R5 run", int'(pw_o), 30);

    // R6 cap inside a burst, then recovery straight to run
    set_pw(5, 20, 255);
    strobe();
    chk("R4 burst again", int'(burst_o), 1);
    set_pw(5, 20, 15);
    strobe();
    chk("R6 burst cap", int'(pw_o), 15);
    set_pw(40, 20, 255);
    strobe();
    chk("R5 exit to run", int'(pw_o), 40);
    chk("R5 exit burst flag", int'(burst_o), 0);

    // R7 qualification
    cs_i = 8'd40; strobe();
    chk("R7 one cycle", int'(sr_en_o), 1);
    cs_i = 8'd60; strobe();
    cs_i = 8'd40; strobe();
    chk("R7 restart", int'(sr_en_o), 1);
    strobe();
    chk("R7 enter dcm", int'(sr_en_o), 0);
    // R8 hysteresis band
    cs_i = 8'd55; strobe(); strobe();
    chk("R8 in band", int'(sr_en_o), 0);
    cs_i = 8'd65; strobe();
    chk("R8 one cycle", int'(sr_en_o), 0);
    strobe();
    chk("R8 exit dcm", int'(sr_en_o), 1);

    // R9 straps without strobes
    force_dcm_i = 1'b1;
    @(negedge clk);
    chk("R9 force", int'(sr_en_o), 0);
    force_dcm_i = 1'b0; no_dcm_i = 1'b1;
    @(negedge clk);
    chk("R9 no dcm", int'(sr_en_o), 1);
    cs_i = 8'd0; strobe(); strobe();
    chk("R9 no dcm holds", int'(sr_en_o), 1);
    no_dcm_i = 1'b0;
    strobe(); strobe();
    chk("R7 after strap", int'(sr_en_o), 0);

    // R1 reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 re-reset pw", int'(pw_o), 0);
    chk("R1 re-reset sr", int'(sr_en_o), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule